// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of a conditional branch from its fetch address. Two component predictors run side by side. The per-address table is indexed by the address alone. The correlated table is indexed by the address mixed with a shift register that holds a summary of the most recent fetch groups. A third table of small saturating counters picks, for each address, which of the two components to trust.

A lookup is purely combinational. The fetch stage presents an address and gets back the final guess, both component guesses and the history value in the same cycle. The fetch pipeline carries the two component guesses and the history value alongside the branch. When the branch resolves, it returns them with the real outcome on the update port. The history register advances once per fetch group, not once per branch: it takes a 1 when any branch in the group was taken and a 0 otherwise.

Top module: `tourney_bp`

## Requirements
- R1: The per-address table index is fetch address bits [12:2]. Address bits outside that range have no effect on which entry is read or written.
- R2: The correlated table index is fetch address bits [12:2] XOR the 11-bit history value shown on `lk_hist`.
- R3: `lk_use_global` is 1 when the selector counter at the lookup index is 2 or 3 (counter MSB set), and 0 when it is 0 or 1. `lk_taken` equals `lk_global` when `lk_use_global` is 1, and `lk_local` otherwise.
- R4: An accepted update writes `upd_taken` into the per-address entry at the index of `upd_pc`. A lookup of that index in the next cycle shows the written value.
- R5: An accepted update writes `upd_taken` into the correlated entry at index `upd_pc[12:2] ^ upd_hist`. The current history value plays no part in choosing that entry.
- R6: The selector counter at the update index changes only when `upd_local` differs from `upd_global`. It then moves one step toward global (+1) if `upd_global` equals `upd_taken`, and one step toward local (-1) otherwise. It saturates at 0 and 3.
- R7: When `grp_valid` is 1, the history shifts left by one at the clock edge, takes `grp_taken` into bit 0 and drops bit 10. When `grp_valid` is 0, the history holds its value.
- R8: While `rst_n` is low and right after it rises, every component entry reads 0 (not taken), every selector counter is 1 (weakly local) and the history is 0.
- R9: A lookup made in the same cycle as an update to the same entry returns the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Lookup fetch address |
| lk_taken | output | 1 | Final direction guess, 1 = taken |
| lk_local | output | 1 | Per-address component guess |
| lk_global | output | 1 | Correlated component guess |
| lk_use_global | output | 1 | 1 when the correlated guess was chosen |
| lk_hist | output | 11 | History value used by this lookup |
| upd_valid | input | 1 | Update request this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the branch |
| upd_local | input | 1 | Per-address guess given at lookup time |
| upd_global | input | 1 | Correlated guess given at lookup time |
| upd_hist | input | 11 | History value given at lookup time |
| grp_valid | input | 1 | A fetch group ends this cycle |
| grp_taken | input | 1 | At least one branch in that group was taken |

## Verification
Lookup results are combinational, so they are due in the same cycle as the address. The bench drives each step on the falling edge and samples 2 ns later, before the next rising edge. Updates and history shifts take effect at the next rising edge. Their effect is therefore checked in the step after the one that issued them. A lookup in the issuing step is expected to show the old contents, which is how the read-before-write rule is checked. The vector table is laid out so that every row's expected value describes the state left by all earlier rows. Selector steps, saturation at both ends, index aliasing and the history hash each show up as a change in the row that follows the stimulus.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
   typedef enum logic {
      SRC_LOCAL  = 1'b0,
      SRC_GLOBAL = 1'b1
   } pred_src_e;

   // Direction in which a selector counter must move after a disagreement.
   function automatic pred_src_e winner(input logic global_guess, input logic outcome);
      return (global_guess == outcome) ? SRC_GLOBAL : SRC_LOCAL;
   endfunction
endpackage

// File: rtl/tdp_bit_table.sv
module tdp_bit_table #(
   parameter int IDX_W = 11,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit
);
   logic [DEPTH-1:0] bits_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (wr_en) begin
         bits_q[wr_idx] <= wr_bit;
      end
   end

   assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/tdp_sel_table.sv
module tdp_sel_table
   import tdp_pkg::*;
#(
   parameter int IDX_W = 11,
   parameter int CTR_W = 2,
   localparam int DEPTH = 1 << IDX_W,
   localparam logic [CTR_W-1:0] CTR_MAX = '1,
   localparam logic [CTR_W-1:0] CTR_WEAK_LOCAL = CTR_W'((1 << (CTR_W - 1)) - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output pred_src_e        rd_src,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  pred_src_e        wr_dir
);
   logic [CTR_W-1:0] ctr_q [DEPTH];
   logic [CTR_W-1:0] cur;
   logic [CTR_W-1:0] nxt;

   assign cur = ctr_q[wr_idx];

   always_comb begin
      nxt = cur;
      if (wr_dir == SRC_GLOBAL) begin
         if (cur != CTR_MAX) nxt = cur + 1'b1;
      end else begin
         if (cur != '0) nxt = cur - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_LOCAL;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= nxt;
      end
   end

   assign rd_src = pred_src_e'(ctr_q[rd_idx][CTR_W-1]);
endmodule

// File: rtl/tdp_ghist.sv
module tdp_ghist #(
   parameter int HIST_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grp_valid,
   input  logic              grp_taken,
   output logic [HIST_W-1:0] hist
);
   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (grp_valid) begin
         hist_q <= {hist_q[HIST_W-2:0], grp_taken};
      end
   end

   assign hist = hist_q;
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
   import tdp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PC_LSB = 2,
   parameter int IDX_W  = 11,
   parameter int HIST_W = 11,
   parameter int CTR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_taken,
   output logic              lk_local,
   output logic              lk_global,
   output logic              lk_use_global,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic              upd_taken,
   input  logic              upd_local,
   input  logic              upd_global,
   input  logic [HIST_W-1:0] upd_hist,
   input  logic              grp_valid,
   input  logic              grp_taken
);
   localparam int IDX_HI = PC_LSB + IDX_W - 1;

   // Elaboration-time parameter checks
   if (HIST_W > IDX_W) begin : g_bad_hist
      $error("HIST_W must not exceed IDX_W");
   end
   if (HIST_W < 2) begin : g_bad_hist_min
      $error("HIST_W must be at least 2");
   end
   if (CTR_W < 2) begin : g_bad_ctr
      $error("CTR_W must be at least 2");
   end
   if (PC_LSB < 1 || IDX_HI >= ADDR_W - 1) begin : g_bad_addr
      $error("index field must sit strictly inside the address");
   end

   logic [IDX_W-1:0] lk_idx, upd_idx;
   logic [IDX_W-1:0] lk_gidx, upd_gidx;
   logic [IDX_W-1:0] lk_hist_ext, upd_hist_ext;
   logic [HIST_W-1:0] hist;
   pred_src_e         lk_src;

   assign lk_idx  = lk_pc[IDX_HI:PC_LSB];
   assign upd_idx = upd_pc[IDX_HI:PC_LSB];

   // History is widened to the index width; only the chosen variant is built.
   if (HIST_W == IDX_W) begin : g_hist_full
      assign lk_hist_ext  = hist;
      assign upd_hist_ext = upd_hist;
   end else begin : g_hist_pad
      assign lk_hist_ext  = {{(IDX_W - HIST_W){1'b0}}, hist};
      assign upd_hist_ext = {{(IDX_W - HIST_W){1'b0}}, upd_hist};
   end

   assign lk_gidx  = lk_idx ^ lk_hist_ext;
   assign upd_gidx = upd_idx ^ upd_hist_ext;

   logic unused_pc_bits;
   assign unused_pc_bits = ^{lk_pc[ADDR_W-1:IDX_HI+1], lk_pc[PC_LSB-1:0],
                             upd_pc[ADDR_W-1:IDX_HI+1], upd_pc[PC_LSB-1:0]};

   tdp_bit_table #(.IDX_W(IDX_W)) u_local (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_idx),
      .rd_bit (lk_local),
      .wr_en  (upd_valid),
      .wr_idx (upd_idx),
      .wr_bit (upd_taken)
   );

   tdp_bit_table #(.IDX_W(IDX_W)) u_global (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_gidx),
      .rd_bit (lk_global),
      .wr_en  (upd_valid),
      .wr_idx (upd_gidx),
      .wr_bit (upd_taken)
   );

   tdp_sel_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_idx),
      .rd_src (lk_src),
      .wr_en  (upd_valid && (upd_local != upd_global)),
      .wr_idx (upd_idx),
      .wr_dir (winner(upd_global, upd_taken))
   );

   tdp_ghist #(.HIST_W(HIST_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .grp_valid (grp_valid),
      .grp_taken (grp_taken),
      .hist      (hist)
   );

   assign lk_use_global = (lk_src == SRC_GLOBAL);
   assign lk_taken      = lk_use_global ? lk_global : lk_local;
   assign lk_hist       = hist;
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
   parameter int ADDR_W = 32,
   parameter int PC_LSB = 2,
   parameter int IDX_W  = 11,
   parameter int HIST_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] lk_pc,
   input logic              lk_taken,
   input logic              lk_local,
   input logic              lk_global,
   input logic              lk_use_global,
   input logic [HIST_W-1:0] lk_hist,
   input logic              upd_valid,
   input logic [ADDR_W-1:0] upd_pc,
   input logic              upd_taken,
   input logic              upd_local,
   input logic              upd_global,
   input logic [HIST_W-1:0] upd_hist,
   input logic              grp_valid,
   input logic              grp_taken
);
   localparam int IDX_HI = PC_LSB + IDX_W - 1;

   logic [IDX_W-1:0] li, ui, lg, ug;
   assign li = lk_pc[IDX_HI:PC_LSB];
   assign ui = upd_pc[IDX_HI:PC_LSB];
   assign lg = li ^ IDX_W'(lk_hist);
   assign ug = ui ^ IDX_W'(upd_hist);

   logic unused_chk;
   assign unused_chk = ^{lk_pc, upd_pc};

   logic rst_seen_q;
   always_ff @(posedge clk) rst_seen_q <= rst_n;

   // R8: history is clear in the first cycle after reset release
   always_ff @(posedge clk) begin
      if (rst_n && !rst_seen_q) begin
         p_reset_hist_r8: assert (lk_hist == '0);
      end
   end

   // R3: when both components agree the final guess follows them
   p_agree_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_local == lk_global) |-> (lk_taken == lk_local));

   // R4
   p_local_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(upd_valid) && li == $past(ui)) |-> (lk_local == $past(upd_taken)));

   // R5
   p_global_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(upd_valid) && lg == $past(ug)) |-> (lk_global == $past(upd_taken)));

   // R6: no disagreeing update at this index leaves the choice unchanged
   p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (li == $past(li) &&
       (!$past(upd_valid) || $past(upd_local) == $past(upd_global) || $past(ui) != li))
      |-> (lk_use_global == $past(lk_use_global)));

   // R7
   p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grp_valid |=> (lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(grp_taken)}));

   p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_valid |=> $stable(lk_hist));
endmodule

bind tourney_bp tourney_bp_chk #(
   .ADDR_W(ADDR_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
   .lk_local(lk_local), .lk_global(lk_global), .lk_use_global(lk_use_global),
   .lk_hist(lk_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
   .upd_taken(upd_taken), .upd_local(upd_local), .upd_global(upd_global),
   .upd_hist(upd_hist), .grp_valid(grp_valid), .grp_taken(grp_taken)
);

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken, lk_local, lk_global, lk_use_global;
   logic [10:0] lk_hist;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;
   logic [10:0] upd_hist = '0;
   logic        grp_valid = 1'b0, grp_taken = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   tourney_bp u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .lk_local(lk_local), .lk_global(lk_global), .lk_use_global(lk_use_global),
      .lk_hist(lk_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_local(upd_local), .upd_global(upd_global),
      .upd_hist(upd_hist), .grp_valid(grp_valid), .grp_taken(grp_taken)
   );

   localparam logic [31:0] PA = 32'h0000_0010; // index 4
   localparam logic [31:0] PB = 32'h0000_2010; // index 4, differs above bit 12
   localparam logic [31:0] PC = 32'h0000_0040; // index 16
   localparam logic [31:0] PZ = 32'h0;

   typedef struct packed {
      logic [3:0]  req;
      logic        uv;
      logic [31:0] upc;
      logic        ut, ul, ug;
      logic [10:0] uh;
      logic        gv, gt;
      logic [31:0] lpc;
      logic [3:0]  flags;  // {local, global, use_global, taken}
      logic [10:0] hist;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{4'd8, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b0000, 11'd0}, // R8
      '{4'd9, 1'b1, PA, 1'b1, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b0000, 11'd0}, // R9
      '{4'd4, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b1101, 11'd0}, // R4
      '{4'd5, 1'b1, PA, 1'b0, 1'b1, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b1101, 11'd0}, // R5
      '{4'd6, 1'b1, PA, 1'b1, 1'b0, 1'b1, 11'd5, 1'b0, 1'b0, PA, 4'b0010, 11'd0}, // R6
      '{4'd3, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b1, 1'b1, PA, 4'b1010, 11'd0}, // R3
      '{4'd2, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b1, 1'b0, PA, 4'b1010, 11'd1}, // R2
      '{4'd7, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b1, 1'b1, PA, 4'b1010, 11'd2}, // R7
      '{4'd2, 1'b1, PA, 1'b0, 1'b1, 1'b1, 11'd5, 1'b0, 1'b0, PA, 4'b1111, 11'd5}, // R2
      '{4'd6, 1'b1, PA, 1'b1, 1'b1, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b0010, 11'd5}, // R6
      '{4'd6, 1'b1, PA, 1'b1, 1'b1, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b1010, 11'd5}, // R6
      '{4'd3, 1'b1, PA, 1'b1, 1'b1, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b1001, 11'd5}, // R3
      '{4'd6, 1'b1, PA, 1'b1, 1'b1, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b1001, 11'd5}, // R6
      '{4'd6, 1'b1, PA, 1'b0, 1'b1, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b1001, 11'd5}, // R6 low sat
      '{4'd6, 1'b1, PA, 1'b1, 1'b0, 1'b1, 11'd0, 1'b0, 1'b0, PA, 4'b0000, 11'd5}, // R6
      '{4'd6, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, PA, 4'b1010, 11'd5}, // R6
      '{4'd6, 1'b1, PC, 1'b1, 1'b0, 1'b1, 11'd0, 1'b0, 1'b0, PC, 4'b0000, 11'd5}, // R6
      '{4'd6, 1'b1, PC, 1'b1, 1'b0, 1'b1, 11'd0, 1'b0, 1'b0, PC, 4'b1010, 11'd5}, // R6
      '{4'd6, 1'b1, PC, 1'b1, 1'b0, 1'b1, 11'd0, 1'b0, 1'b0, PC, 4'b1010, 11'd5}, // R6 high sat
      '{4'd6, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, PC, 4'b1010, 11'd5}, // R6
      '{4'd1, 1'b0, PZ, 1'b0, 1'b0, 1'b0, 11'd0, 1'b0, 1'b0, PB, 4'b1010, 11'd5}  // R1
   };

   task automatic check(input string tag, input logic [14:0] exp);
      logic [14:0] act;
      act = {lk_local, lk_global, lk_use_global, lk_taken, lk_hist};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {local,global,use_global,taken,hist} = %b/%h expected %b/%h",
                  tag, act[14:11], act[10:0], exp[14:11], exp[10:0]);
      end
   endtask

   task automatic idle_inputs();
      upd_valid = 1'b0; grp_valid = 1'b0; grp_taken = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Vector table: inputs set on the falling edge, outputs sampled before the rise.
      for (int i = 0; i < NV; i++) begin
         upd_valid = VEC[i].uv;  upd_pc = VEC[i].upc; upd_taken = VEC[i].ut;
         upd_local = VEC[i].ul;  upd_global = VEC[i].ug; upd_hist = VEC[i].uh;
         grp_valid = VEC[i].gv;  grp_taken = VEC[i].gt; lk_pc = VEC[i].lpc;
         #2;
         check($sformatf("R%0d row %0d", VEC[i].req, i), {VEC[i].flags, VEC[i].hist});
         @(negedge clk);
      end
      idle_inputs();

      // R7: eleven taken groups fill the history, then a not-taken group enters bit 0
      for (int k = 0; k < 11; k++) begin
         grp_valid = 1'b1; grp_taken = 1'b1;
         @(negedge clk);
      end
      grp_valid = 1'b0; lk_pc = PA; #2;
      check("R7 full history", {4'b1010, 11'h7FF});
      @(negedge clk);
      grp_valid = 1'b1; grp_taken = 1'b0;
      @(negedge clk);
      idle_inputs(); #2;
      check("R7 oldest bit dropped", {lk_local, lk_global, lk_use_global, lk_taken, 11'h7FE});
      // R7: history holds without group ends, even while updates arrive
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         upd_valid = 1'b1; upd_pc = PC; upd_taken = 1'b0; upd_local = 1'b0; upd_global = 1'b0;
      end
      @(negedge clk);
      idle_inputs(); #2;
      n_checks++;
      if (lk_hist !== 11'h7FE) begin
         n_fail++;
         $display("FAIL R7 hold: hist %h expected 7fe", lk_hist);
      end

      // R8: reset clears tables and history
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      lk_pc = PA; #1;
      check("R8 after reset A", {4'b0000, 11'd0});
      lk_pc = PC; #1;
      check("R8 after reset C", {4'b0000, 11'd0});
      // R8: weakly local - one disagreement won by global flips the choice
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = PA; upd_taken = 1'b1; upd_local = 1'b0; upd_global = 1'b1;
      upd_hist = '0;
      @(negedge clk);
      idle_inputs(); lk_pc = PA; #2;
      check("R8 weakly local start", {4'b1111, 11'd0});

      // R1: top index bit selects a different entry; bits above bit 12 are ignored
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = 32'h0000_1FFC; upd_taken = 1'b1;
      upd_local = 1'b0; upd_global = 1'b0;
      @(negedge clk);
      idle_inputs();
      lk_pc = 32'h0000_0FFC; #1;
      check("R1 bit 12 distinct", {4'b0000, 11'd0});
      lk_pc = 32'hFFFF_FFFC; #1;
      check("R1 upper bits ignored", {4'b1101, 11'd0});

      done = 1'b1;
      finish_run();
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end
endmodule